// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave

This block is a two-wire serial bus slave that keeps seven 8-bit configuration registers for an on-chip clock generator. A bus master writes the bank by sending the block's write address byte, then two header bytes whose values the block acknowledges and throws away, then a stream of data bytes. The data bytes fill register 0, then register 1, and so on upward. No address pointer is sent. A STOP may come after any whole byte, and the registers loaded up to that point keep their new values.

A master reads the bank back by sending the read address byte. The block then returns register 0 and the registers after it in order until the master refuses a byte. The bus lines are sampled by the system clock through two-flop synchronisers. The block pulls SDA low through an open-drain enable and never drives SCL. The full bank is exported flat, and the mode fields of register 0 are also decoded for the clock logic.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, register 0 reads 00h, registers 1 to 6 read FFh, and sda_oe is 0. Register k sits on cfg_regs[8k+7:8k].
- R2: The address byte D2h (7-bit address 69h, write) is acknowledged by pulling SDA low in the ninth clock. Any other address except D3h gets no acknowledge and leaves every register unchanged.
- R3: In a write, the two bytes after the address are acknowledged and their values have no effect on any register.
- R4: The data bytes of a write are acknowledged and stored in register 0, 1, 2 and so on in order of arrival.
- R5: A STOP after any whole data byte keeps the registers already written and leaves the rest at their old values.
- R6: Register 6 stores and returns the value written to it. Data bytes beyond register 6 are acknowledged and change nothing.
- R7: The address byte D3h is acknowledged. The block then sends register 0 first and the following registers in order, MSB first. Reads past register 6 return FFh. After a master NACK the block releases SDA.
- R8: A START during a byte abandons that byte without writing it. Registers already written are kept, and the next byte is taken as an address.
- R9: op_mode equals register 0 bits 1:0 (00 normal, 01 test, 10 spread enabled, 11 outputs floated). spread_down equals bit 2 (1 = downward spread). depth_half equals bit 7 (1 = the narrower modulation depth).
- R10: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cfg_regs | output | 56 | Register bank, register k at bits 8k+7:8k |
| op_mode | output | 2 | Decoded operating mode from register 0 |
| spread_down | output | 1 | Spread direction from register 0 |
| depth_half | output | 1 | Modulation depth select from register 0 |

## Verification
The bench checks that the two header bytes are dropped. A design that counted one header byte too few would move every register by one and store the count byte in register 0. Writes that run past register 6 are checked against a design whose pointer wraps: such a design would overwrite register 0 with the late bytes. Reads past the end are checked to return FFh, not to repeat register 0. A START that arrives halfway through a byte is checked not to commit the partial shift register to the next register. Random streams of data-byte counts and values are also compared with a bench model after each write and after each read.

// File: rtl/clkcfg_pkg.sv
// Package clkcfg_pkg
// Shared types and constants for the configuration register slave.
// Assumes one device address and a fixed pair of header bytes on writes.
package clkcfg_pkg;

    // Number of header bytes after a write address that are acknowledged and dropped
    localparam int HDR_BYTES = 2;

    // Bus engine states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for START
        ST_RX   = 3'd1,   // shifting in a byte on SCL rising edges
        ST_ACK  = 3'd2,   // holding SDA low during the acknowledge clock
        ST_TX   = 3'd3,   // shifting out a read byte on SCL falling edges
        ST_MACK = 3'd4    // sampling the master's acknowledge
    } bus_st_t;

    // Meaning of register 0 bits 1:0
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SPREAD = 2'b10,
        MODE_FLOAT  = 2'b11
    } op_mode_t;

endpackage

// File: rtl/clkcfg_line_sync.sv
// Module clkcfg_line_sync
// Brings SCL and SDA into the clock domain and reports bus events:
// SCL edges, START (SDA falls while SCL high) and STOP (SDA rises while SCL high).
// Assumes STAGES >= 2 and a system clock well above the bus bit rate.
module clkcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains plus one delayed copy for edge detection; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/clkcfg_reg_bank.sv
// Module clkcfg_reg_bank
// Holds the configuration registers with one registered write port and one
// combinational read port. Indices at or beyond NREG read as all ones.
// Assumes the write index is below NREG whenever wr_en is high.
module clkcfg_reg_bank #(
    parameter int         NREG    = 7,
    parameter logic [7:0] RST_R0  = 8'h00,
    parameter logic [7:0] RST_OTH = 8'hFF,
    localparam int        IDX_W   = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic [8*NREG-1:0] cfg_flat
);

    logic [7:0] regs [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            // One storage byte: reset value depends on position, loads on a matching write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= (i == 0) ? RST_R0 : RST_OTH;
                else if (wr_en && (wr_idx == IDX_W'(i)))
                    regs[i] <= wr_data;
            end
            assign cfg_flat[8*i +: 8] = regs[i];
        end
    endgenerate

    // Read mux: returns all ones past the end of the bank
    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NREG; k++)
            if (rd_idx == IDX_W'(k)) rd_data = regs[k];
    end

    // R6: the write port never targets a register beyond the bank
    a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NREG)));

    // R5: without a write strobe the bank contents hold
    a_r5_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_flat));

endmodule

// File: rtl/clkcfg_bus_fsm.sv
// Module clkcfg_bus_fsm
// Byte-level slave engine: matches the address, acknowledges bytes, drops the
// header bytes of a write, streams data into ascending registers and streams
// registers out on a read. Assumes synchronised bus inputs and event pulses.
module clkcfg_bus_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = 7,
    localparam int        IDX_W    = $clog2(NREG + 1),
    localparam int        HDR_W    = $clog2(HDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_oe
);

    bus_st_t          st;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic             addr_ph;
    logic             is_rd;
    logic [HDR_W-1:0] hdr_cnt;
    logic [IDX_W-1:0] wr_ptr;
    logic [7:0]       rx_byte;

    // Byte as it stands after the current SCL rising edge
    assign rx_byte = {shreg[6:0], sda_s};
    assign rd_idx  = wr_ptr;

    // Main bus sequencer: events first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            addr_ph <= 1'b0;
            is_rd   <= 1'b0;
            hdr_cnt <= '0;
            wr_ptr  <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                st      <= ST_RX;
                bitcnt  <= '0;
                addr_ph <= 1'b1;
                is_rd   <= 1'b0;
                hdr_cnt <= '0;
                wr_ptr  <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == 4'd7) begin
                                if (addr_ph) begin
                                    if (rx_byte[7:1] == DEV_ADDR) is_rd <= rx_byte[0];
                                    else                          st    <= ST_IDLE;
                                end else if (hdr_cnt != HDR_W'(HDR_BYTES)) begin
                                    hdr_cnt <= hdr_cnt + 1'b1;
                                end else if (wr_ptr < IDX_W'(NREG)) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= wr_ptr;
                                    wr_data <= rx_byte;
                                    wr_ptr  <= wr_ptr + 1'b1;
                                end
                            end
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            st     <= ST_ACK;
                            sda_oe <= 1'b1;
                            bitcnt <= '0;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            addr_ph <= 1'b0;
                            bitcnt  <= '0;
                            if (is_rd) begin
                                st     <= ST_TX;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                if (wr_ptr < IDX_W'(NREG)) wr_ptr <= wr_ptr + 1'b1;
                            end else begin
                                st     <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                st     <= ST_MACK;
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (sda_s) st     <= ST_IDLE;
                            else       bitcnt <= 4'd1;
                        end else if (scl_fall && bitcnt == 4'd1) begin
                            st     <= ST_TX;
                            bitcnt <= '0;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            if (wr_ptr < IDX_W'(NREG)) wr_ptr <= wr_ptr + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: the data line enable only moves while the synchronised clock is low
    a_r10_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R8: a START always releases the line and restarts bit counting
    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (!sda_oe && bitcnt == 4'd0 && st == ST_RX));

    // R2: an idle engine never pulls the line
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R4: the bit counter never passes the acknowledge slot
    a_r4_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);

endmodule

// File: rtl/clkcfg_i2c_slave.sv
// Module clkcfg_i2c_slave
// Top of the configuration register slave: synchroniser, bus engine and
// register bank, plus decoding of the mode fields in register 0.
// Assumes an external open-drain pad driven by sda_oe and a slow bus.
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h69,
    parameter int         NREG       = 7,
    parameter int         SYNC_STAGE = 2,
    localparam int        IDX_W      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [8*NREG-1:0] cfg_regs,
    output logic [1:0]        op_mode,
    output logic              spread_down,
    output logic              depth_half
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;
    op_mode_t         mode_dec;

    clkcfg_line_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    clkcfg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .sda_oe   (sda_oe)
    );

    clkcfg_reg_bank #(.NREG(NREG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cfg_flat (cfg_regs)
    );

    // Field decode of register 0 for the clock logic
    assign mode_dec    = op_mode_t'(cfg_regs[1:0]);
    assign op_mode     = mode_dec;
    assign spread_down = cfg_regs[2];
    assign depth_half  = cfg_regs[7];

endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;

    localparam int Q = 8;  // quarter bus bit in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [55:0] cfg_regs;
    logic [1:0]  op_mode;
    logic        spread_down, depth_half;
    logic        sda_bus;

    int errors = 0;
    int checks = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic [7:0] mdl [7];
    logic [7:0] wbuf [16];

    assign sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    clkcfg_i2c_slave u_clkcfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs), .op_mode(op_mode),
        .spread_down(spread_down), .depth_half(depth_half)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [55:0] model_flat();
        logic [55:0] f;
        for (int i = 0; i < 7; i++) f[8*i +: 8] = mdl[i];
        return f;
    endfunction

    function automatic logic [7:0] model_rd(input int idx);
        return (idx < 7) ? mdl[idx] : 8'hFF;
    endfunction

    // R10 monitor: the enable must not move while the master holds SCL high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) r10_viol++;
        oe_prev <= sda_oe;
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Full write: address, two header bytes, n data bytes from wbuf, STOP
    task automatic do_write(input int n, input logic [7:0] hcmd, input logic [7:0] hcnt);
        bit a;
        bus_start();
        send_byte(8'hD2, a); chk(a, "R2 write address ack", a, 1);
        send_byte(hcmd, a);  chk(a, "R3 header byte 1 ack", a, 1);
        send_byte(hcnt, a);  chk(a, "R3 header byte 2 ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk(a, (i < 7) ? "R4 data ack" : "R6 excess data ack", a, 1);
            if (i < 7) mdl[i] = wbuf[i];
        end
        bus_stop();
        tick(4);
        chk(cfg_regs == model_flat(), "R4 R5 R6 bank after write", cfg_regs, model_flat());
    endtask

    // Read of n bytes, master NACKs the last one
    task automatic do_read(input int n);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a); chk(a, "R7 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == model_rd(i), "R7 read data", b, model_rd(i));
        end
        chk(sda_oe == 1'b0, "R7 release after NACK", sda_oe, 0);
        bus_stop();
        tick(4);
    endtask

    initial begin
        bit a;
        int n;
        logic [31:0] seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 7; i++) mdl[i] = (i == 0) ? 8'h00 : 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        chk(cfg_regs == 56'hFFFF_FFFF_FFFF_00, "R1 reset bank", cfg_regs, 56'hFFFF_FFFF_FFFF_00);
        chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);

        // R2 foreign address: no ack, nothing written
        bus_start();
        send_byte(8'hA4, a);
        chk(!a, "R2 foreign address nack", a, 0);
        send_byte(8'h12, a);
        send_byte(8'h34, a);
        send_byte(8'h56, a);
        bus_stop(); tick(4);
        chk(cfg_regs == model_flat(), "R2 no change on foreign address", cfg_regs, model_flat());

        // R3 R4 R9: header values ignored, mode fields decoded
        wbuf[0] = 8'h86; wbuf[1] = 8'h0F; wbuf[2] = 8'hA5;
        do_write(3, 8'h00, 8'h07);
        chk(op_mode == 2'b10, "R9 op_mode spread", op_mode, 2'b10);
        chk(spread_down == 1'b1, "R9 spread_down", spread_down, 1);
        chk(depth_half == 1'b1, "R9 depth_half", depth_half, 1);
        chk(cfg_regs[31:24] == 8'hFF, "R3 header did not reach register 3", cfg_regs[31:24], 8'hFF);

        wbuf[0] = 8'h03;
        do_write(1, 8'hFF, 8'hFF);
        chk(op_mode == 2'b11 && !spread_down && !depth_half, "R9 float mode fields",
            {op_mode, spread_down, depth_half}, 4'b1100);

        // R5: STOP after two bytes keeps the rest
        wbuf[0] = 8'h01; wbuf[1] = 8'h22;
        do_write(2, 8'h10, 8'h02);
        chk(cfg_regs[23:16] == 8'hA5, "R5 register 2 kept", cfg_regs[23:16], 8'hA5);

        // R6: nine bytes, last two discarded
        for (int i = 0; i < 9; i++) wbuf[i] = 8'h30 + 8'(i);
        do_write(9, 8'h00, 8'h00);
        chk(cfg_regs[55:48] == 8'h36, "R6 register 6 stored", cfg_regs[55:48], 8'h36);
        chk(cfg_regs[7:0] == 8'h30, "R6 no wrap into register 0", cfg_regs[7:0], 8'h30);

        // R7: read past the end
        do_read(9);

        // R8: START halfway through the byte for register 1
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h5A, a); mdl[0] = 8'h5A;
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b0; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
        tick(2);
        chk(cfg_regs == model_flat(), "R8 aborted byte not written", cfg_regs, model_flat());
        send_byte(8'hD2, a); chk(a, "R8 address after abort", a, 1);
        send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h3C, a); mdl[0] = 8'h3C;
        bus_stop(); tick(4);
        chk(cfg_regs == model_flat(), "R8 bank after restart", cfg_regs, model_flat());

        // Random streams
        for (int t = 0; t < 8; t++) begin
            n = int'($urandom_range(0, 9));
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(n, 8'($urandom), 8'($urandom));
            do_read(int'($urandom_range(1, 9)));
        end

        chk(r10_viol == 0, "R10 enable moved while SCL high", r10_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule